// File: doc/BRIEF.md
# Eight-Point In-Place FFT Engine

This block computes an eight-point discrete Fourier transform of a frame of real 16-bit samples. It holds one working memory of eight complex words and a single complex butterfly unit. A small sequencer walks three radix-2 decimation-in-frequency stages over that memory. In each stage it picks pairs of words, runs them through the butterfly with the matching twiddle factor, and writes both results back into the words they came from.

A user loads the eight samples through a write port while the engine is idle. The user then pulses a start input. After a fixed number of cycles the engine raises a completion flag, and the spectrum can be read bin by bin through a combinational read port. The butterfly results land in bit-reversed positions, and the read port undoes this, so read address k returns bin X(k). The internal words carry three guard bits, so no input frame can overflow them.

Top module: `fft8_engine`

## Requirements
- R1: After reset, `done` is 0 and every read address returns 0 in both the real and imaginary outputs.
- R2: While the engine is not computing, `wr_en` stores `wr_data` into memory word `wr_addr`, sign-extended to 19 bits, with a zero imaginary part. Before a transform, read address k returns the word stored at position bitrev(k), where bitrev swaps address bits 0 and 2.
- R3: Results are 19-bit signed values and are exact wherever no scaling by 0.7071 is involved: X(0) equals the plain sum of the samples and X(4) equals the alternating sum (even samples minus odd samples). Neither value overflows, including for all-maximum and all-minimum frames.
- R4: For every k in 0..7, the value read is X(k) = sum over n of x(n)·e^(−j2πnk/8), within ±4 LSB in both parts. The 0.7071 twiddle scale is 23170/2^15, rounded by adding 2^14 and then shifting right arithmetically.
- R5: Bins are returned in natural order: read address k gives X(k), not the bit-reversed word order the stages leave in memory.
- R6: When `start` is sampled high while idle or finished, `done` rises exactly 24 clock edges later. That is 12 butterflies of 2 cycles each, and the count does not depend on the data.
- R7: An accepted `start` clears `done` at the next edge. Once set, `done` stays high until the next `start` or reset.
- R8: While the engine is computing, `start` pulses and sample writes are ignored. The completion time and every result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transform of the current memory contents |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 3 | Sample index to write |
| wr_data | input | 16 | Signed real sample |
| rd_addr | input | 3 | Frequency bin to read |
| rd_re | output | 19 | Real part of the selected bin |
| rd_im | output | 19 | Imaginary part of the selected bin |
| done | output | 1 | Transform complete |

## Verification
The no-overflow property relies on each stage growing magnitudes by at most a factor of two. It therefore assumes the memory holds only sign-extended 16-bit samples at start, which the 16-bit sample port ensures. The latency property counts edges from an accepted start and assumes `start` arrives as pulses. The bench holds to both. It also adds a start pulse and a sample write in the middle of one run, to show they are dropped. The stimulus covers impulses, constant frames at both signed extremes, an alternating frame, a tone, and a sweep of pseudo-random frames.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

    localparam int N_PTS    = 8;
    localparam int ADDR_W   = $clog2(N_PTS);
    localparam int STAGES   = ADDR_W;
    localparam int PAIRS    = N_PTS / 2;
    localparam int PAIR_W   = $clog2(PAIRS);
    localparam int TW_W     = PAIR_W;
    localparam int STAGE_W  = $clog2(STAGES + 1);
    localparam int DATA_W   = 16;
    localparam int GUARD_W  = STAGES;
    localparam int INT_W    = DATA_W + GUARD_W;
    localparam int WIDE_W   = INT_W + 2;
    localparam int TW_FRAC  = 15;
    localparam int TW_C     = $rtoi(0.7071067811865476 * (2.0 ** TW_FRAC) + 0.5);
    localparam int PROD_W   = WIDE_W + TW_FRAC + 2;
    localparam int BF_CYC   = 2;
    localparam int LATENCY  = BF_CYC * STAGES * PAIRS;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic signed [INT_W-1:0] re;
        logic signed [INT_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [WIDE_W-1:0] re;
        logic signed [WIDE_W-1:0] im;
    } wide_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FIN
    } seq_e;

    function automatic addr_t bit_rev(input addr_t a);
        addr_t r;
        for (int i = 0; i < ADDR_W; i++) r[i] = a[ADDR_W-1-i];
        return r;
    endfunction

    function automatic logic signed [WIDE_W-1:0] widen(input logic signed [INT_W-1:0] v);
        return WIDE_W'(v);
    endfunction

    function automatic logic signed [INT_W-1:0] narrow(input logic signed [WIDE_W-1:0] v);
        return v[INT_W-1:0];
    endfunction

    // Multiply by cos(45 deg) in fixed point, round half up.
    function automatic logic signed [WIDE_W-1:0] scale_c(input logic signed [WIDE_W-1:0] v);
        logic signed [PROD_W-1:0] p;
        p = PROD_W'(v) * PROD_W'(TW_C);
        p = p + PROD_W'(1 <<< (TW_FRAC - 1));
        p = p >>> TW_FRAC;
        return p[WIDE_W-1:0];
    endfunction

    function automatic logic fits(input logic signed [WIDE_W-1:0] v);
        return (v[WIDE_W-1:INT_W-1] == '0) || (v[WIDE_W-1:INT_W-1] == '1);
    endfunction

endpackage

// File: rtl/fft8_seq.sv
module fft8_seq
    import fft8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              latch,
    output logic              commit,
    output addr_t             addr_a,
    output addr_t             addr_b,
    output logic [TW_W-1:0]   tw
);

    seq_e                 state;
    logic [STAGE_W-1:0]   stage;
    logic [PAIR_W-1:0]    pair;
    logic                 phase;

    logic [STAGE_W-1:0]   span_log;
    addr_t                p_ext;
    addr_t                mask;
    addr_t                off;
    addr_t                grp;
    addr_t                tw_full;

    assign busy   = (state == SQ_RUN);
    assign done   = (state == SQ_FIN);
    assign latch  = busy && !phase;
    assign commit = busy && phase;

    // Pair addresses: span halves every stage (4, 2, 1).
    always_comb begin
        span_log = STAGE_W'(STAGES - 1) - stage;
        p_ext    = ADDR_W'(pair);
        mask     = (addr_t'(1) << span_log) - addr_t'(1);
        off      = p_ext & mask;
        grp      = p_ext >> span_log;
        addr_a   = (grp << (span_log + STAGE_W'(1))) | off;
        addr_b   = addr_a | (addr_t'(1) << span_log);
        tw_full  = off << stage;
        tw       = tw_full[TW_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            stage <= '0;
            pair  <= '0;
            phase <= 1'b0;
        end else begin
            case (state)
                SQ_RUN: begin
                    phase <= ~phase;
                    if (phase) begin
                        if (pair == PAIR_W'(PAIRS - 1)) begin
                            pair <= '0;
                            if (stage == STAGE_W'(STAGES - 1)) begin
                                stage <= '0;
                                state <= SQ_FIN;
                            end else begin
                                stage <= stage + STAGE_W'(1);
                            end
                        end else begin
                            pair <= pair + PAIR_W'(1);
                        end
                    end
                end
                default: begin
                    if (start) begin
                        state <= SQ_RUN;
                        stage <= '0;
                        pair  <= '0;
                        phase <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly
    import fft8_pkg::*;
(
    input  cplx_t             a,
    input  cplx_t             b,
    input  logic [TW_W-1:0]   tw,
    output cplx_t             y0,
    output cplx_t             y1,
    output logic              ovf
);

    wide_t s;
    wide_t d;
    wide_t t;

    always_comb begin
        s.re = widen(a.re) + widen(b.re);
        s.im = widen(a.im) + widen(b.im);
        d.re = widen(a.re) - widen(b.re);
        d.im = widen(a.im) - widen(b.im);
        case (tw)
            2'd0: t = d;
            2'd1: begin
                t.re = scale_c(d.re + d.im);
                t.im = scale_c(d.im - d.re);
            end
            2'd2: begin
                t.re = d.im;
                t.im = -d.re;
            end
            default: begin
                t.re = scale_c(d.im - d.re);
                t.im = -scale_c(d.re + d.im);
            end
        endcase
        y0.re = narrow(s.re);
        y0.im = narrow(s.im);
        y1.re = narrow(t.re);
        y1.im = narrow(t.im);
        ovf   = !(fits(s.re) && fits(s.im) && fits(t.re) && fits(t.im));
    end

endmodule

// File: rtl/fft8_mem.sv
module fft8_mem
    import fft8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_en,
    input  addr_t  ld_addr,
    input  cplx_t  ld_word,
    input  logic   bf_we,
    input  addr_t  addr_a,
    input  addr_t  addr_b,
    input  cplx_t  wa,
    input  cplx_t  wb,
    output cplx_t  qa,
    output cplx_t  qb,
    input  addr_t  rd_addr,
    output cplx_t  rd_q
);

    cplx_t words [N_PTS];

    for (genvar i = 0; i < N_PTS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (ld_en && ld_addr == addr_t'(i)) begin
                words[i] <= ld_word;
            end else if (bf_we && addr_a == addr_t'(i)) begin
                words[i] <= wa;
            end else if (bf_we && addr_b == addr_t'(i)) begin
                words[i] <= wb;
            end
        end
    end

    assign qa   = words[addr_a];
    assign qb   = words[addr_b];
    assign rd_q = words[rd_addr];

endmodule

// File: rtl/fft8_engine.sv
module fft8_engine
    import fft8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [INT_W-1:0]  rd_re,
    output logic signed [INT_W-1:0]  rd_im,
    output logic                     done
);

    logic              busy;
    logic              bf_latch;
    logic              bf_commit;
    logic              bf_ovf;
    addr_t             addr_a;
    addr_t             addr_b;
    logic [TW_W-1:0]   tw;
    cplx_t             qa, qb;
    cplx_t             op_a, op_b;
    cplx_t             y0, y1;
    cplx_t             ld_word;
    cplx_t             rd_q;
    logic              ld_en;

    assign ld_en      = wr_en && !busy;
    assign ld_word.re = INT_W'(wr_data);
    assign ld_word.im = '0;

    fft8_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .done   (done),
        .latch  (bf_latch),
        .commit (bf_commit),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .tw     (tw)
    );

    fft8_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (wr_addr),
        .ld_word (ld_word),
        .bf_we   (bf_commit),
        .addr_a  (addr_a),
        .addr_b  (addr_b),
        .wa      (y0),
        .wb      (y1),
        .qa      (qa),
        .qb      (qb),
        .rd_addr (bit_rev(rd_addr)),
        .rd_q    (rd_q)
    );

    // Operand register: first butterfly cycle reads, second writes back.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
        end else if (bf_latch) begin
            op_a <= qa;
            op_b <= qb;
        end
    end

    fft8_bfly u_bfly (
        .a   (op_a),
        .b   (op_b),
        .tw  (tw),
        .y0  (y0),
        .y1  (y1),
        .ovf (bf_ovf)
    );

    assign rd_re = rd_q.re;
    assign rd_im = rd_q.im;

endmodule

// File: rtl/fft8_engine_chk.sv
module fft8_engine_chk
    import fft8_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start,
    input logic done,
    input logic busy,
    input logic commit,
    input logic bf_ovf
);

    localparam int CNT_W = $clog2(LATENCY + 2);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && !busy) begin
            cnt <= CNT_W'(1);
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!done && !busy)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) commit |-> !bf_ovf); // R3

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> (cnt == CNT_W'(LATENCY + 1))); // R6

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && !done)); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start && !commit) |=> busy); // R8

endmodule

bind fft8_engine fft8_engine_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .commit (bf_commit),
    .bf_ovf (bf_ovf)
);

// File: tb/fft8_engine_tb.sv
`timescale 1ns/1ps
module fft8_engine_tb;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic               wr_en;
    logic [2:0]         wr_addr;
    logic signed [15:0] wr_data;
    logic [2:0]         rd_addr;
    logic signed [18:0] rd_re;
    logic signed [18:0] rd_im;
    logic               done;

    int checks = 0;
    int failures = 0;
    int smp [8];
    int lfsr = 32'h1ACE_5EED;

    always #2 clk = ~clk;

    fft8_engine u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_re   (rd_re),
        .rd_im   (rd_im),
        .done    (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic int rev3(input int k);
        return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
    endfunction

    function automatic int next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ int'($unsigned(lfsr) >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic load_frame();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 3'(i);
            wr_data = 16'(smp[i]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: raw word order before the transform
    task automatic check_loaded();
        for (int k = 0; k < 8; k++) begin
            rd_addr = 3'(k);
            #1;
            chk(int'(rd_re) == smp[rev3(k)] && rd_im == 0, "R2", "loaded word",
                longint'(rd_re), longint'(smp[rev3(k)]));
        end
    endtask

    task automatic run_frame(input bit inject);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7", "done cleared by start", longint'(done), 0);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                start   = 1'b1;
                wr_en   = 1'b1;
                wr_addr = 3'd0;
                wr_data = 16'sh1234;
            end else if (inject && n == 6) begin
                start = 1'b0;
                wr_en = 1'b0;
            end
            if (done || n > 100) break;
        end
        chk(n == 24, inject ? "R8" : "R6", "cycles to done", longint'(n), 24);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R7", "done held", longint'(done), 1);
    endtask

    task automatic check_bins(input string req);
        real er, ei, ang, dre, dim;
        int s0, s4;
        s0 = 0;
        s4 = 0;
        for (int n = 0; n < 8; n++) begin
            s0 += smp[n];
            s4 += ((n & 1) != 0) ? -smp[n] : smp[n];
        end
        for (int k = 0; k < 8; k++) begin
            er = 0.0;
            ei = 0.0;
            for (int n = 0; n < 8; n++) begin
                ang = 2.0 * 3.14159265358979 * real'(n * k) / 8.0;
                er  = er + real'(smp[n]) * $cos(ang);
                ei  = ei - real'(smp[n]) * $sin(ang);
            end
            rd_addr = 3'(k);
            #1;
            dre = real'(rd_re) - er;
            dim = real'(rd_im) - ei;
            if (dre < 0.0) dre = -dre;
            if (dim < 0.0) dim = -dim;
            chk(dre <= 4.0, req, $sformatf("re X(%0d)", k), longint'(rd_re), longint'($rtoi(er)));
            chk(dim <= 4.0, req, $sformatf("im X(%0d)", k), longint'(rd_im), longint'($rtoi(ei)));
        end
        // R3: exact bins
        rd_addr = 3'd0;
        #1;
        chk(int'(rd_re) == s0 && rd_im == 0, "R3", "exact X(0)", longint'(rd_re), longint'(s0));
        rd_addr = 3'd4;
        #1;
        chk(int'(rd_re) == s4 && rd_im == 0, "R3", "exact X(4)", longint'(rd_re), longint'(s4));
    endtask

    task automatic do_frame(input string req, input bit inject);
        load_frame();
        check_loaded();
        run_frame(inject);
        check_bins(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        rst     = 1'b1;
        start   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        for (int k = 0; k < 8; k++) begin
            rd_addr = 3'(k);
            #1;
            chk(rd_re == 0 && rd_im == 0, "R1", "bin after reset", longint'(rd_re), 0);
        end

        // R4: impulse at sample 0
        foreach (smp[i]) smp[i] = (i == 0) ? 1000 : 0;
        do_frame("R4", 1'b0);

        // R5: impulse at sample 3 exposes bin ordering
        foreach (smp[i]) smp[i] = (i == 3) ? 20000 : 0;
        do_frame("R5", 1'b0);

        // R3: signed extremes
        foreach (smp[i]) smp[i] = 32767;
        do_frame("R3", 1'b0);
        foreach (smp[i]) smp[i] = -32768;
        do_frame("R3", 1'b0);
        foreach (smp[i]) smp[i] = ((i & 1) != 0) ? -32768 : 32767;
        do_frame("R3", 1'b0);

        // R8: start and write injected mid-run on a tone frame
        foreach (smp[i]) smp[i] = $rtoi(30000.0 * $cos(2.0 * 3.14159265358979 * real'(i) / 8.0));
        do_frame("R8", 1'b1);

        // R4: pseudo-random sweep
        for (int f = 0; f < 40; f++) begin
            foreach (smp[i]) smp[i] = int'(16'(next_rand()) ^ 16'h0) - ((next_rand() & 1) != 0 ? 0 : 0);
            foreach (smp[i]) smp[i] = int'($signed(16'(smp[i])));
            do_frame("R4", 1'b0);
        end

        summary();
        $finish;
    end

endmodule